// File: doc/BRIEF.md
# JESD204B Lane Synchronisation Sequencer

This block is the link-layer controller for a single transmit lane. Each clock it produces one octet, plus a flag that marks the octet as a control character, for a downstream 8b/10b encoder. It keeps a local multiframe counter made of an octet-in-frame index and a frame-in-multiframe index. From these it flags the last octet of every multiframe.

While the receiver holds its sync request active (`sync_n` low), the lane sends comma characters so that the receiver can lock onto code groups. After the request is released, the sequencer waits for a multiframe boundary, optionally plus up to three more. It then sends a four-multiframe initial lane alignment sequence, and after that it forwards user octets. The alignment sequence can be skipped. The comma pattern is selectable. The multiframe counter can be preloaded with a programmable frame index on reset.

Configuration inputs are expected to be static and are changed only while reset is held. Reset is synchronous and active low.

Top module: `jsync_seq`

## Requirements
- R1: After reset, and for every octet that follows a cycle in which `sync_n` was low, with `cfg_idle_alt`=0, the lane outputs 8'hBC with `tx_is_ctrl`=1.
- R2: With `cfg_idle_alt`=1, the comma phase outputs a pair of octets over and over: first 8'hBC (ctrl=1), then 8'h50 (ctrl=0). The pair order restarts with 8'hBC on each entry into the comma phase, including the first cycle after reset.
- R3: A multiframe is F×K octets long, where F=`cfg_octets_m1`+1 and K=`cfg_frames_m1`+1. `lmfc_edge` is high exactly on the last octet of each multiframe. With no preload, the first such octet is the (F×K)-th cycle after reset release.
- R4: With `cfg_lmfc_force`=1, reset loads the frame index with `cfg_lmfc_init` (which must be below K). The first `lmfc_edge` then comes (K−init)×F cycles after reset release.
- R5: With `cfg_ila_delay`=0, the alignment sequence starts on the octet right after the first `lmfc_edge` octet during which `sync_n` was high.
- R6: With `cfg_ila_delay`=D, the first D `lmfc_edge` octets with `sync_n` high are passed over. The sequence starts after the (D+1)-th such octet.
- R7: The alignment sequence is four multiframes long. Each multiframe opens with 8'h1C (ctrl) and closes with 8'h7C (ctrl). Every other position p (0-based within the multiframe) carries p mod 256 as data, except where R8 applies.
- R8: In the second alignment multiframe, position 1 is 8'h9C (ctrl). Positions 2 to 5 carry, as data, LANE_ID, F−1, K−1, and the 8-bit sum of those three. F×K must be at least 7.
- R9: Right after the alignment sequence, `tx_octet` equals `user_octet` with ctrl=0 and `user_taken`=1. This phase starts on a multiframe boundary.
- R10: With `cfg_ila_skip`=1, user data starts at the octet where the alignment sequence would have started.
- R11: If `sync_n` is low during the alignment or data phase, the next octet is a comma (R1/R2 pattern restarting at 8'hBC) and `user_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_n | input | 1 | Receiver sync request, active low |
| cfg_octets_m1 | input | 8 | Octets per frame minus one |
| cfg_frames_m1 | input | 5 | Frames per multiframe minus one |
| cfg_ila_delay | input | 2 | Extra multiframes to wait before alignment |
| cfg_ila_skip | input | 1 | Skip the alignment sequence |
| cfg_idle_alt | input | 1 | Comma pattern select: 0 = BC BC, 1 = BC 50 |
| cfg_lmfc_force | input | 1 | Use the preload value for the frame index on reset |
| cfg_lmfc_init | input | 5 | Frame index preload value |
| user_octet | input | 8 | User payload octet |
| tx_octet | output | 8 | Octet to the encoder |
| tx_is_ctrl | output | 1 | Octet is a control character |
| user_taken | output | 1 | `user_octet` is consumed this cycle |
| lmfc_edge | output | 1 | Last octet of a multiframe |

## Verification
The assertions assume three things about the inputs. Every configuration input holds still outside reset. The preload value is below K. F×K leaves room for the configuration block ahead of the closing symbol. The stimulus changes configuration only while `rst_n` is low, uses preloads below K, and uses multiframes of 8 to 12 octets. `sync_n` is moved only between whole cycles, once to release and once to re-request. This places each release and re-request at a known offset from a boundary, so the expected start cycle can be derived from the boundary arithmetic alone.

// File: rtl/jsync_pkg.sv
package jsync_pkg;

    typedef enum logic [1:0] {
        ST_COMMA = 2'd0,
        ST_ILA   = 2'd1,
        ST_DATA  = 2'd2
    } seq_state_e;

    localparam logic [7:0] CH_COMMA    = 8'hBC;
    localparam logic [7:0] CH_ALT      = 8'h50;
    localparam logic [7:0] CH_MF_START = 8'h1C;
    localparam logic [7:0] CH_MF_END   = 8'h7C;
    localparam logic [7:0] CH_CFG_MARK = 8'h9C;

    localparam int ILA_MF = 4;
    localparam int MF_W   = $clog2(ILA_MF);

endpackage

// File: rtl/jsync_lmfc.sv
module jsync_lmfc #(
    parameter int OCT_W = 8,
    parameter int FRM_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCT_W-1:0] octets_m1,
    input  logic [FRM_W-1:0] frames_m1,
    input  logic             force_init,
    input  logic [FRM_W-1:0] init_frame,
    output logic [OCT_W-1:0] oct_idx,
    output logic [FRM_W-1:0] frm_idx,
    output logic             mf_edge
);

    typedef struct packed {
        logic [OCT_W-1:0] oct;
        logic [FRM_W-1:0] frm;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!rst_n) begin
            cnt_d.oct = '0;
            cnt_d.frm = force_init ? init_frame : '0;
        end else if (cnt_q.oct == octets_m1) begin
            cnt_d.oct = '0;
            cnt_d.frm = (cnt_q.frm == frames_m1) ? '0 : cnt_q.frm + 1'b1;
        end else begin
            cnt_d.oct = cnt_q.oct + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign oct_idx = cnt_q.oct;
    assign frm_idx = cnt_q.frm;
    assign mf_edge = (cnt_q.oct == octets_m1) && (cnt_q.frm == frames_m1);

    AST_LMFC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (oct_idx <= octets_m1) && (frm_idx <= frames_m1)); // R3
    AST_LMFC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        mf_edge |=> (oct_idx == '0) && (frm_idx == '0)); // R3
    AST_LMFC_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (oct_idx == '0) && (frm_idx == (force_init ? init_frame : '0))); // R4

endmodule

// File: rtl/jsync_octet_mux.sv
module jsync_octet_mux
    import jsync_pkg::*;
#(
    parameter int OCT_W   = 8,
    parameter int FRM_W   = 5,
    parameter int LANE_ID = 0
) (
    input  seq_state_e       state,
    input  logic [MF_W-1:0]  ila_mf,
    input  logic             alt_phase,
    input  logic             idle_alt,
    input  logic [OCT_W-1:0] oct_idx,
    input  logic [FRM_W-1:0] frm_idx,
    input  logic [OCT_W-1:0] octets_m1,
    input  logic [FRM_W-1:0] frames_m1,
    input  logic [7:0]       user_octet,
    output logic [7:0]       octet,
    output logic             is_ctrl
);

    localparam int LIN_W = OCT_W + FRM_W + 1;

    logic [LIN_W-1:0] frame_len;
    logic [LIN_W-1:0] lin;
    logic             mf_last;
    logic [7:0]       cfg_sum;

    always_comb begin
        frame_len = LIN_W'(octets_m1) + LIN_W'(1);
        lin       = LIN_W'(frm_idx) * frame_len + LIN_W'(oct_idx);
        mf_last   = (oct_idx == octets_m1) && (frm_idx == frames_m1);
        cfg_sum   = 8'(LANE_ID) + 8'(octets_m1) + 8'(frames_m1);
    end

    always_comb begin
        octet   = user_octet;
        is_ctrl = 1'b0;
        case (state)
            ST_COMMA: begin
                if (idle_alt && alt_phase) begin
                    octet = CH_ALT;
                end else begin
                    octet   = CH_COMMA;
                    is_ctrl = 1'b1;
                end
            end
            ST_ILA: begin
                octet = lin[7:0];
                if (lin == '0) begin
                    octet   = CH_MF_START;
                    is_ctrl = 1'b1;
                end else if (mf_last) begin
                    octet   = CH_MF_END;
                    is_ctrl = 1'b1;
                end else if (ila_mf == MF_W'(1)) begin
                    if (lin == LIN_W'(1)) begin
                        octet   = CH_CFG_MARK;
                        is_ctrl = 1'b1;
                    end else if (lin == LIN_W'(2)) begin
                        octet = 8'(LANE_ID);
                    end else if (lin == LIN_W'(3)) begin
                        octet = 8'(octets_m1);
                    end else if (lin == LIN_W'(4)) begin
                        octet = 8'(frames_m1);
                    end else if (lin == LIN_W'(5)) begin
                        octet = cfg_sum;
                    end
                end
            end
            default: begin
                octet   = user_octet;
                is_ctrl = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/jsync_seq.sv
module jsync_seq
    import jsync_pkg::*;
#(
    parameter int OCT_W   = 8,
    parameter int FRM_W   = 5,
    parameter int DLY_W   = 2,
    parameter int LANE_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_n,
    input  logic [OCT_W-1:0] cfg_octets_m1,
    input  logic [FRM_W-1:0] cfg_frames_m1,
    input  logic [DLY_W-1:0] cfg_ila_delay,
    input  logic             cfg_ila_skip,
    input  logic             cfg_idle_alt,
    input  logic             cfg_lmfc_force,
    input  logic [FRM_W-1:0] cfg_lmfc_init,
    input  logic [7:0]       user_octet,
    output logic [7:0]       tx_octet,
    output logic             tx_is_ctrl,
    output logic             user_taken,
    output logic             lmfc_edge
);

    typedef struct packed {
        seq_state_e       state;
        logic [DLY_W-1:0] dly;
        logic [MF_W-1:0]  mf;
        logic             tog;
    } seq_t;

    seq_t s_d, s_q;

    logic [OCT_W-1:0] oct_idx;
    logic [FRM_W-1:0] frm_idx;
    logic             mf_edge;

    jsync_lmfc #(
        .OCT_W (OCT_W),
        .FRM_W (FRM_W)
    ) u_lmfc (
        .clk        (clk),
        .rst_n      (rst_n),
        .octets_m1  (cfg_octets_m1),
        .frames_m1  (cfg_frames_m1),
        .force_init (cfg_lmfc_force),
        .init_frame (cfg_lmfc_init),
        .oct_idx    (oct_idx),
        .frm_idx    (frm_idx),
        .mf_edge    (mf_edge)
    );

    always_comb begin
        s_d     = s_q;
        s_d.tog = (s_q.state == ST_COMMA) ? ~s_q.tog : 1'b0;
        if (!rst_n) begin
            s_d.state = ST_COMMA;
            s_d.dly   = cfg_ila_delay;
            s_d.mf    = '0;
            s_d.tog   = 1'b0;
        end else if (!sync_n) begin
            s_d.state = ST_COMMA;
            s_d.dly   = cfg_ila_delay;
            s_d.mf    = '0;
        end else begin
            case (s_q.state)
                ST_COMMA: begin
                    if (mf_edge) begin
                        if (s_q.dly == '0) begin
                            s_d.state = cfg_ila_skip ? ST_DATA : ST_ILA;
                            s_d.mf    = '0;
                        end else begin
                            s_d.dly = s_q.dly - 1'b1;
                        end
                    end
                end
                ST_ILA: begin
                    if (mf_edge) begin
                        if (s_q.mf == MF_W'(ILA_MF - 1)) begin
                            s_d.state = ST_DATA;
                        end else begin
                            s_d.mf = s_q.mf + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    jsync_octet_mux #(
        .OCT_W   (OCT_W),
        .FRM_W   (FRM_W),
        .LANE_ID (LANE_ID)
    ) u_mux (
        .state      (s_q.state),
        .ila_mf     (s_q.mf),
        .alt_phase  (s_q.tog),
        .idle_alt   (cfg_idle_alt),
        .oct_idx    (oct_idx),
        .frm_idx    (frm_idx),
        .octets_m1  (cfg_octets_m1),
        .frames_m1  (cfg_frames_m1),
        .user_octet (user_octet),
        .octet      (tx_octet),
        .is_ctrl    (tx_is_ctrl)
    );

    logic in_comma, in_ila, in_data;
    assign in_comma   = (s_q.state == ST_COMMA);
    assign in_ila     = (s_q.state == ST_ILA);
    assign in_data    = (s_q.state == ST_DATA);
    assign user_taken = in_data;
    assign lmfc_edge  = mf_edge;

    AST_COMMA_WHILE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n && !cfg_idle_alt) |=> (tx_is_ctrl && tx_octet == CH_COMMA)); // R1
    AST_ALT_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_comma && cfg_idle_alt && !tx_is_ctrl) |=> (!in_comma || tx_octet == CH_COMMA)); // R2
    AST_ILA_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ila) |-> $past(mf_edge)); // R5
    AST_ILA_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ila) |-> (tx_is_ctrl && tx_octet == CH_MF_START)); // R7
    AST_DATA_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_data) |-> $past(mf_edge)); // R9
    AST_DROP_STOPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_n |=> !user_taken); // R11

endmodule

// File: tb/jsync_seq_tb.sv
module jsync_seq_tb;

    localparam int LANE = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sync_n = 1'b0;
    logic [7:0] cfg_octets_m1 = '0;
    logic [4:0] cfg_frames_m1 = '0;
    logic [1:0] cfg_ila_delay = '0;
    logic       cfg_ila_skip = 1'b0;
    logic       cfg_idle_alt = 1'b0;
    logic       cfg_lmfc_force = 1'b0;
    logic [4:0] cfg_lmfc_init = '0;
    logic [7:0] user_octet = '0;
    logic [7:0] tx_octet;
    logic       tx_is_ctrl;
    logic       user_taken;
    logic       lmfc_edge;

    always #5 clk = ~clk;

    jsync_seq #(.LANE_ID(LANE)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .sync_n         (sync_n),
        .cfg_octets_m1  (cfg_octets_m1),
        .cfg_frames_m1  (cfg_frames_m1),
        .cfg_ila_delay  (cfg_ila_delay),
        .cfg_ila_skip   (cfg_ila_skip),
        .cfg_idle_alt   (cfg_idle_alt),
        .cfg_lmfc_force (cfg_lmfc_force),
        .cfg_lmfc_init  (cfg_lmfc_init),
        .user_octet     (user_octet),
        .tx_octet       (tx_octet),
        .tx_is_ctrl     (tx_is_ctrl),
        .user_taken     (user_taken),
        .lmfc_edge      (lmfc_edge)
    );

    typedef struct packed {
        logic [7:0] oct;
        logic       ctrl;
        logic       taken;
        logic       bnd;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    string btag_q[$];
    int    checks = 0;
    int    errors = 0;

    // Monitor: compares each expected item against the outputs mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() != 0) begin
                exp_t  e;
                string t;
                string bt;
                e  = exp_q.pop_front();
                t  = tag_q.pop_front();
                bt = btag_q.pop_front();
                checks++;
                if ({tx_octet, tx_is_ctrl, user_taken} !== {e.oct, e.ctrl, e.taken}) begin
                    errors++;
                    $display("FAIL %s: octet/ctrl/taken got %h/%b/%b expected %h/%b/%b",
                             t, tx_octet, tx_is_ctrl, user_taken, e.oct, e.ctrl, e.taken);
                end
                checks++;
                if (lmfc_edge !== e.bnd) begin
                    errors++;
                    $display("FAIL %s: lmfc_edge got %b expected %b", bt, lmfc_edge, e.bnd);
                end
            end
        end
    end

    // Driver: runs one scenario and pushes the expected stream
    task automatic run_case(input int f, input int k, input int dly, input int skip,
                            input int alt, input int frc, input int init,
                            input int n_low, input int drop, input int total);
        int fk;
        int s;
        int cnt;
        fk = f * k;
        rst_n = 1'b0;
        sync_n = 1'b0;
        cfg_octets_m1 = 8'(f - 1);
        cfg_frames_m1 = 5'(k - 1);
        cfg_ila_delay = 2'(dly);
        cfg_ila_skip = skip[0];
        cfg_idle_alt = alt[0];
        cfg_lmfc_force = frc[0];
        cfg_lmfc_init = 5'(init);
        repeat (2) @(posedge clk);
        s = -1;
        cnt = 0;
        for (int n = 0; n < total && s < 0; n++) begin
            if (n >= n_low && ((n + (frc != 0 ? init * f : 0)) % fk) == fk - 1) begin
                if (cnt == dly) s = n + 1;
                else cnt++;
            end
        end
        for (int n = 0; n < total; n++) begin
            exp_t  e;
            string t;
            int    pos;
            int    entry;
            @(posedge clk);
            #1;
            rst_n = 1'b1;
            sync_n = (n >= n_low) && (drop < 0 || n < drop);
            user_octet = 8'(n * 7 + 3);
            pos = (n + (frc != 0 ? init * f : 0)) % fk;
            e.bnd = (pos == fk - 1);
            e.taken = 1'b0;
            entry = -1;
            if (drop >= 0 && n > drop) begin
                entry = drop + 1;
                t = "R11";
            end else if (s < 0 || n < s) begin
                entry = 0;
                t = (n == 0) ? "R1 reset" : (alt != 0 ? "R2" : "R1");
            end
            if (entry >= 0) begin
                if (alt != 0 && ((n - entry) % 2) == 1) begin
                    e.oct = 8'h50; e.ctrl = 1'b0;
                end else begin
                    e.oct = 8'hBC; e.ctrl = 1'b1;
                end
            end else if (skip == 0 && n < s + 4 * fk) begin
                int p;
                int m;
                int q;
                p = n - s;
                m = p / fk;
                q = p % fk;
                t = "R7";
                e.oct = 8'(q);
                e.ctrl = 1'b0;
                if (q == 0) begin
                    e.oct = 8'h1C; e.ctrl = 1'b1;
                    if (m == 0) t = (dly != 0) ? "R6" : "R5";
                end else if (q == fk - 1) begin
                    e.oct = 8'h7C; e.ctrl = 1'b1;
                end else if (m == 1 && q >= 1 && q <= 5) begin
                    t = "R8";
                    case (q)
                        1: begin e.oct = 8'h9C; e.ctrl = 1'b1; end
                        2: e.oct = 8'(LANE);
                        3: e.oct = 8'(f - 1);
                        4: e.oct = 8'(k - 1);
                        default: e.oct = 8'(LANE + f - 1 + k - 1);
                    endcase
                end
            end else begin
                t = (skip != 0) ? "R10" : "R9";
                e.oct = 8'(n * 7 + 3);
                e.ctrl = 1'b0;
                e.taken = 1'b1;
            end
            exp_q.push_back(e);
            tag_q.push_back(t);
            btag_q.push_back(frc != 0 ? "R4" : "R3");
        end
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // R1 R3 R5 R7 R8 R9 R11: F=2 K=4, no delay, re-request during data
        run_case(2, 4, 0, 0, 0, 0, 0, 5, 50, 60);
        // R2 R4 R6 R8 R11: F=1 K=8, preload 3, delay 2, alternate comma
        run_case(1, 8, 2, 0, 1, 1, 3, 6, 65, 72);
        // R10 R6: F=4 K=3, skip alignment, delay 1
        run_case(4, 3, 1, 1, 0, 0, 0, 2, 30, 40);
        // R6 R11 R2: F=2 K=5, delay 3, re-request during alignment
        run_case(2, 5, 3, 0, 1, 0, 0, 0, 45, 55);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule